// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block collects interrupt events for a multi-channel serial bus controller and merges them into a single interrupt line. Events arrive in two groups. System-wide events land in a system status word, and a system mask word decides which of them may drive the interrupt. Per-channel events land in one 16-bit status word per logical channel. Each channel's control word holds eight enable bits that gate the low eight status bits of that channel. A read-only channel summary word has one bit per channel and shows which channels currently hold a pending, unmasked interrupt.

Software reaches all of this through a simple word-addressed read/write port. Status words are write-one-to-clear. A summary bit is sticky. Hardware sets it when its channel raises an event on an unmasked bit. Software cannot write it, and it drops only once no unmasked status bit of that channel remains set. The address map uses a two-bit region field in the top address bits. Region 0 holds the system words at offsets 0 (system status), 1 (system mask) and 2 (channel summary). Region 1 holds the channel control word n at offset n. Region 2 holds the channel status word n at offset n. Any other address reads as zero and ignores writes.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the system status, every channel status and the summary read 0, the system mask reads 0xFFFF, every channel control word reads 0x00FF0000 (all eight enables in bits 23:16 masked), and `irq` is 0.
- R2: A 1 on `sys_evt[i]` sets system status bit i. Writing data to the system status word clears exactly the bits where the data holds a 1, and a written 0 leaves its bit unchanged.
- R3: A system status bit drives `irq` only while its system mask bit is 0. A mask bit of 1 suppresses the interrupt but the status bit is still recorded.
- R4: A channel event (`ch_evt_valid` with `ch_evt_id` = n) ORs `ch_evt_bits` into channel n's 16-bit status word. Writes to that word are write-one-to-clear, and writing 0xFFFF clears it entirely.
- R5: Channel status bit j (j < 8) is unmasked when bit 16+j of the channel's control word is 0. Bits 8 to 15 are never masked. An event on an unmasked bit of channel n sets summary bit n. An event only on masked bits sets status but leaves the summary bit at 0.
- R6: A summary bit is sticky. Writes to the summary word have no effect. The bit stays set while any unmasked status bit of its channel is set. It clears once none is, whether the clear comes from a status write or from masking. Unmasking an already pending bit does not set it.
- R7: When a hardware event and a software clear hit the same status bit in the same cycle, the bit stays set. This holds for both system and channel status.
- R8: `irq` is registered. It is 1 exactly one clock after an unmasked system status bit or any summary bit is set, and it falls one clock after the last one goes away.
- R9: Reads return data in `rd_data` one clock after `rd_en`. Unmapped addresses, including channel offsets at or above the channel count, read 0. `rd_data` is 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address (region in top two bits) |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, one clock after `rd_en` |
| sys_evt | input | SYS_W | System event strobes, one per status bit |
| ch_evt_valid | input | 1 | A channel event is present this cycle |
| ch_evt_id | input | $clog2(NUM_CH) | Logical channel of the event |
| ch_evt_bits | input | CH_STAT_W | Status bits raised by the channel event |
| irq | output | 1 | Registered combined interrupt |

## Verification
Two things can land on the same status bit in one clock: a hardware event that sets the bit and a software write-one-to-clear. The bench drives both at once on a system bit and on a channel bit. It expects the bit to read back as set and the channel summary to stay high. It also pairs an event on one bit with a clear of a neighbouring bit, and expects only the cleared bit to drop. Around these cases, near-exhaustive sweeps cover every system bit and every channel/bit pair under alternating enable patterns. For each pair the bench works out the expected status, summary and `irq` values by arithmetic on the channel and bit numbers.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [1:0] {
    RGN_SYS  = 2'd0,
    RGN_CTRL = 2'd1,
    RGN_STAT = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  localparam int SYS_STAT_OFS = 0;
  localparam int SYS_MASK_OFS = 1;
  localparam int SUMMARY_OFS  = 2;

endpackage

// File: rtl/irq_sys_unit.sv
module irq_sys_unit #(
  parameter int SYS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYS_W-1:0] evt,
  input  logic             clr_we,
  input  logic [SYS_W-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [SYS_W-1:0] mask_wdata,
  output logic [SYS_W-1:0] stat,
  output logic [SYS_W-1:0] mask,
  output logic             pending
);

  logic [SYS_W-1:0] clr_eff;
  logic [SYS_W-1:0] stat_next;

  always_comb begin
    clr_eff   = clr_we ? clr_bits : '0;
    // a set from hardware outranks a clear in the same cycle
    stat_next = (stat & ~clr_eff) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      mask <= '1;
    end else begin
      stat <= stat_next;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign pending = |(stat & ~mask);

  AST_SYS_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt))); // R7

  AST_SYS_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(evt)) == '0)); // R2

endmodule

// File: rtl/irq_chan_slice.sv
module irq_chan_slice #(
  parameter int STAT_W = 16,
  parameter int EN_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_hit,
  input  logic [STAT_W-1:0] evt_bits,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic              ctrl_we,
  input  logic [EN_W-1:0]   ctrl_wdata,
  output logic [STAT_W-1:0] stat,
  output logic [EN_W-1:0]   en_mask,
  output logic              summary
);

  localparam int FREE_W = STAT_W - EN_W;

  logic [EN_W-1:0]   en_next;
  logic [STAT_W-1:0] unmask_next;
  logic [STAT_W-1:0] unmask_cur;
  logic [STAT_W-1:0] stat_next;
  logic              set_now;
  logic              sum_next;

  always_comb begin
    en_next     = ctrl_we ? ctrl_wdata : en_mask;
    unmask_next = {{FREE_W{1'b1}}, ~en_next};
    unmask_cur  = {{FREE_W{1'b1}}, ~en_mask};
    stat_next   = (stat & ~(clr_we ? clr_bits : '0)) | (evt_hit ? evt_bits : '0);
    set_now     = evt_hit && ((evt_bits & unmask_next) != '0);
    // sticky: held until no unmasked status bit is left
    sum_next    = (summary || set_now) && ((stat_next & unmask_next) != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat    <= '0;
      en_mask <= '1;
      summary <= 1'b0;
    end else begin
      stat    <= stat_next;
      en_mask <= en_next;
      summary <= sum_next;
    end
  end

  AST_SUM_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    summary |-> ((stat & unmask_cur) != '0)); // R6

  AST_SUM_RISE_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
    (!summary && !evt_hit) |=> !summary); // R5

  AST_CH_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    evt_hit |=> ((stat & $past(evt_bits)) == $past(evt_bits))); // R7

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int SYS_W     = 16,
  parameter int CH_STAT_W = 16,
  parameter int CH_EN_W   = 8,
  parameter int CH_EN_LSB = 16,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         rd_data,
  input  logic [SYS_W-1:0]          sys_evt,
  input  logic                      ch_evt_valid,
  input  logic [$clog2(NUM_CH)-1:0] ch_evt_id,
  input  logic [CH_STAT_W-1:0]      ch_evt_bits,
  output logic                      irq
);

  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int LOW_W    = ADDR_W - 2;

  region_e             rgn;
  logic [LOW_W-1:0]    low;
  logic [CH_IDX_W-1:0] idx;
  logic                idx_ok;

  logic [SYS_W-1:0]     sys_stat;
  logic [SYS_W-1:0]     sys_mask;
  logic                 sys_pend;
  logic [CH_STAT_W-1:0] ch_stat [NUM_CH];
  logic [CH_EN_W-1:0]   ch_en   [NUM_CH];
  logic [NUM_CH-1:0]    ch_sum;
  logic [DATA_W-1:0]    rd_mux;
  logic                 unused_wdata;

  assign unused_wdata = ^wr_data;

  always_comb begin
    rgn    = region_e'(addr[ADDR_W-1 -: 2]);
    low    = addr[LOW_W-1:0];
    idx    = low[CH_IDX_W-1:0];
    idx_ok = (32'(low) < NUM_CH);
  end

  irq_sys_unit #(.SYS_W(SYS_W)) u_sys (
    .clk        (clk),
    .rst        (rst),
    .evt        (sys_evt),
    .clr_we     (wr_en && rgn == RGN_SYS && low == LOW_W'(SYS_STAT_OFS)),
    .clr_bits   (wr_data[SYS_W-1:0]),
    .mask_we    (wr_en && rgn == RGN_SYS && low == LOW_W'(SYS_MASK_OFS)),
    .mask_wdata (wr_data[SYS_W-1:0]),
    .stat       (sys_stat),
    .mask       (sys_mask),
    .pending    (sys_pend)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_chan_slice #(.STAT_W(CH_STAT_W), .EN_W(CH_EN_W)) u_slice (
      .clk        (clk),
      .rst        (rst),
      .evt_hit    (ch_evt_valid && ch_evt_id == CH_IDX_W'(c)),
      .evt_bits   (ch_evt_bits),
      .clr_we     (wr_en && rgn == RGN_STAT && idx_ok && idx == CH_IDX_W'(c)),
      .clr_bits   (wr_data[CH_STAT_W-1:0]),
      .ctrl_we    (wr_en && rgn == RGN_CTRL && idx_ok && idx == CH_IDX_W'(c)),
      .ctrl_wdata (wr_data[CH_EN_LSB +: CH_EN_W]),
      .stat       (ch_stat[c]),
      .en_mask    (ch_en[c]),
      .summary    (ch_sum[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (rgn)
      RGN_SYS: begin
        if (low == LOW_W'(SYS_STAT_OFS))     rd_mux[SYS_W-1:0]  = sys_stat;
        else if (low == LOW_W'(SYS_MASK_OFS)) rd_mux[SYS_W-1:0]  = sys_mask;
        else if (low == LOW_W'(SUMMARY_OFS))  rd_mux[NUM_CH-1:0] = ch_sum;
      end
      RGN_CTRL: if (idx_ok) rd_mux[CH_EN_LSB +: CH_EN_W] = ch_en[idx];
      RGN_STAT: if (idx_ok) rd_mux[CH_STAT_W-1:0]        = ch_stat[idx];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_en ? rd_mux : '0;
      irq     <= sys_pend || (ch_sum != '0);
    end
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sys_pend && ch_sum == '0) |=> !irq); // R8

  AST_IRQ_FROM_SYS: assert property (@(posedge clk) disable iff (rst)
    sys_pend |=> irq); // R3

  AST_IRQ_FROM_CH: assert property (@(posedge clk) disable iff (rst)
    (ch_sum != '0) |=> irq); // R5

endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] sys_evt = '0;
  logic        ch_evt_valid = 1'b0;
  logic [4:0]  ch_evt_id = '0;
  logic [15:0] ch_evt_bits = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_status_agg dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .sys_evt(sys_evt),
    .ch_evt_valid(ch_evt_valid), .ch_evt_id(ch_evt_id),
    .ch_evt_bits(ch_evt_bits), .irq(irq)
  );

  localparam logic [9:0] A_SSTAT = 10'h000;
  localparam logic [9:0] A_SMASK = 10'h001;
  localparam logic [9:0] A_SUM   = 10'h002;

  function automatic logic [9:0] a_ctrl(input int ch);
    return 10'h100 + 10'(ch);
  endfunction

  function automatic logic [9:0] a_stat(input int ch);
    return 10'h200 + 10'(ch);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    tick();
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic chk_rd(input string req, input string what,
                        input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, what, d, exp);
  endtask

  task automatic sys_pulse(input logic [15:0] b);
    sys_evt = b;
    tick();
    sys_evt = '0;
  endtask

  task automatic ch_pulse(input int ch, input logic [15:0] b);
    ch_evt_valid = 1'b1; ch_evt_id = 5'(ch); ch_evt_bits = b;
    tick();
    ch_evt_valid = 1'b0; ch_evt_bits = '0;
  endtask

  function automatic logic [31:0] ctrl_word(input logic [7:0] en);
    return {8'h00, en, 16'h0000};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1", "irq after reset", 32'(irq), 32'd0);
    chk_rd("R1", "sys status", A_SSTAT, 32'h0);
    chk_rd("R1", "sys mask", A_SMASK, 32'h0000FFFF);
    chk_rd("R1", "summary", A_SUM, 32'h0);
    for (int ch = 0; ch < 32; ch++) begin
      chk_rd("R1", "ctrl reset", a_ctrl(ch), 32'h00FF0000);
      chk_rd("R1", "ch status reset", a_stat(ch), 32'h0);
    end

    // R9 read path
    chk_rd("R9", "unmapped sys offset", 10'h003, 32'h0);
    chk_rd("R9", "unmapped region", 10'h300, 32'h0);
    chk_rd("R9", "ctrl index out of range", 10'h120, 32'h0);
    tick();
    chk("R9", "idle rd_data", rd_data, 32'h0);

    // R2 R3 sweep over every system bit
    for (int i = 0; i < 16; i++) begin
      logic [15:0] b;
      b = 16'(1 << i);
      sys_pulse(b);
      chk_rd("R2", "sys bit set", A_SSTAT, {16'h0, b});
      chk("R3", "masked sys bit keeps irq low", 32'(irq), 32'd0);
      wr(A_SMASK, {16'h0, ~b});
      chk("R8", "irq one cycle after unmask", 32'(irq), 32'd0);
      tick();
      chk("R3", "unmasked sys bit raises irq", 32'(irq), 32'd1);
      wr(A_SSTAT, 32'h0);
      chk_rd("R2", "writing zero keeps bit", A_SSTAT, {16'h0, b});
      wr(A_SSTAT, {16'h0, ~b});
      chk_rd("R2", "clearing other bits keeps bit", A_SSTAT, {16'h0, b});
      wr(A_SSTAT, {16'h0, b});
      tick();
      chk_rd("R2", "w1c clears bit", A_SSTAT, 32'h0);
      chk("R8", "irq falls after clear", 32'(irq), 32'd0);
      wr(A_SMASK, 32'h0000FFFF);
    end

    // R8 event-to-irq latency
    wr(A_SMASK, 32'h0000FFFE);
    sys_pulse(16'h0001);
    chk("R8", "irq not yet up", 32'(irq), 32'd0);
    tick();
    chk("R8", "irq one cycle after status", 32'(irq), 32'd1);
    wr(A_SSTAT, 32'h1);
    wr(A_SMASK, 32'h0000FFFF);
    tick();
    chk("R8", "irq low again", 32'(irq), 32'd0);

    // R4 R5 sweep over channel and bit
    for (int ch = 0; ch < 32; ch++) begin
      for (int b = 0; b < 16; b++) begin
        logic        unm;
        logic [7:0]  en;
        logic [15:0] bit_v;
        bit_v = 16'(1 << b);
        unm   = (b >= 8) || (((ch + b) & 1) == 0);
        en    = (b < 8 && unm) ? ~8'(1 << b) : 8'hFF;
        wr(a_ctrl(ch), ctrl_word(en));
        ch_pulse(ch, bit_v);
        chk_rd("R4", "ch status set", a_stat(ch), {16'h0, bit_v});
        chk_rd("R5", "summary after event", A_SUM, unm ? 32'(1 << ch) : 32'h0);
        chk("R5", "irq follows summary", 32'(irq), 32'(unm));
        wr(A_SUM, 32'h0);
        chk_rd("R6", "summary write ignored", A_SUM, unm ? 32'(1 << ch) : 32'h0);
        wr(a_stat(ch), 32'h0000FFFF);
        chk_rd("R4", "ch status cleared", a_stat(ch), 32'h0);
        chk_rd("R6", "summary cleared", A_SUM, 32'h0);
      end
      chk_rd("R5", "ctrl readback", a_ctrl(ch), ctrl_word(8'hFF));
      wr(a_ctrl(ch), ctrl_word(8'hFF));
    end

    // R5 two channels at once via never-masked bit 8
    ch_pulse(0, 16'h0100);
    ch_pulse(31, 16'h0100);
    chk_rd("R5", "two summary bits", A_SUM, 32'h80000001);
    wr(a_stat(0), 32'hFFFF);
    chk_rd("R6", "one channel cleared", A_SUM, 32'h80000000);
    wr(a_stat(31), 32'hFFFF);

    // R6 sticky behaviour on channel 7
    wr(a_ctrl(7), ctrl_word(8'hFE));
    ch_pulse(7, 16'h0003);
    chk_rd("R6", "summary set", A_SUM, 32'h80);
    wr(a_stat(7), 32'h0001);
    chk_rd("R6", "only masked bit left", A_SUM, 32'h0);
    chk_rd("R4", "masked bit still pending", a_stat(7), 32'h0002);
    wr(a_stat(7), 32'hFFFF);
    ch_pulse(7, 16'h0101);
    wr(a_stat(7), 32'h0001);
    chk_rd("R6", "bit 8 holds summary", A_SUM, 32'h80);
    wr(A_SUM, 32'hFFFFFFFF);
    chk_rd("R6", "summary write ones ignored", A_SUM, 32'h80);
    wr(a_stat(7), 32'h0100);
    chk_rd("R6", "summary drops", A_SUM, 32'h0);
    wr(A_SUM, 32'hFFFFFFFF);
    chk_rd("R6", "write cannot set summary", A_SUM, 32'h0);
    wr(a_ctrl(7), ctrl_word(8'hFF));
    ch_pulse(7, 16'h0004);
    wr(a_ctrl(7), ctrl_word(8'hFB));
    chk_rd("R6", "unmask pending does not set", A_SUM, 32'h0);
    ch_pulse(7, 16'h0004);
    chk_rd("R6", "new event sets", A_SUM, 32'h80);
    wr(a_ctrl(7), ctrl_word(8'hFF));
    chk_rd("R6", "masking clears summary", A_SUM, 32'h0);
    wr(a_stat(7), 32'hFFFF);

    // R7 event versus clear in the same cycle
    sys_pulse(16'h0008);
    sys_evt = 16'h0008; wr(A_SSTAT, 32'h8); sys_evt = '0;
    chk_rd("R7", "sys event beats clear", A_SSTAT, 32'h8);
    sys_evt = 16'h0010; wr(A_SSTAT, 32'h8); sys_evt = '0;
    chk_rd("R7", "sys neighbour clear", A_SSTAT, 32'h10);
    wr(A_SSTAT, 32'hFFFF);
    wr(a_ctrl(9), ctrl_word(8'hFB));
    ch_pulse(9, 16'h0004);
    ch_evt_valid = 1'b1; ch_evt_id = 5'd9; ch_evt_bits = 16'h0004;
    wr(a_stat(9), 32'hFFFF);
    ch_evt_valid = 1'b0; ch_evt_bits = '0;
    chk_rd("R7", "ch event beats clear", a_stat(9), 32'h4);
    chk_rd("R7", "summary held", A_SUM, 32'h200);
    wr(a_stat(9), 32'hFFFF);
    chk_rd("R7", "final clear", A_SUM, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule